// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out where an instruction's operand lives. It takes a three-bit addressing-mode code, a 16-bit constant from the instruction word, and two register-file read ports: the base and the index. Each port brings both its register number and the value read from that register. From these it forms a 32-bit effective address. It also raises a flag when the operand has to be fetched from memory. In immediate mode it returns the sign-extended constant as the operand itself.

The unit has no register state of its own apart from its output stage, and it never writes back to the register file. Register number zero always counts as the value zero, whatever its read port carries. Because of this, an indexed access through register zero acts as absolute addressing. All results are captured in one output register and appear one clock after the request.

Top module: `eag_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `ea`, `mem_access`, `imm_value` and `illegal` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock; every result belongs to the request accepted on the previous edge.
- R3: Mode code 0 (absolute) gives `ea` = the constant sign-extended from bit 15 to 32 bits, with `mem_access` = 1.
- R4: Mode code 1 (immediate) gives `imm_value` = the sign-extended constant, `mem_access` = 0 and `ea` = 0. In every other mode `imm_value` is 0.
- R5: Mode code 2 (register indirect) gives `ea` = the base value, with `mem_access` = 1.
- R6: Mode code 3 (indexed with constant) gives `ea` = the sign-extended constant + the base value, with `mem_access` = 1.
- R7: Mode code 4 (base plus index) gives `ea` = the base value + the index value, with `mem_access` = 1.
- R8: Mode code 5 (base plus index plus constant) gives `ea` = the sign-extended constant + the base value + the index value, with `mem_access` = 1.
- R9: A register number of 0 on either port makes that operand read as zero, whatever the value on its data input.
- R10: Mode codes 6 and 7 set `illegal` = 1 and force `mem_access`, `ea` and `imm_value` to 0. Legal codes give `illegal` = 0.
- R11: All address sums wrap modulo 2^32.
- R12: While `in_valid` is low, `ea`, `mem_access`, `imm_value` and `illegal` keep their previous values, and `out_valid` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code (0..5 legal) |
| konst | input | 16 | Instruction constant, two's complement |
| base_sel | input | 5 | Register number of the base operand |
| base_val | input | 32 | Value read for the base register |
| index_sel | input | 5 | Register number of the index operand |
| index_val | input | 32 | Value read for the index register |
| out_valid | output | 1 | Registered result valid |
| ea | output | 32 | Registered effective address |
| mem_access | output | 1 | Operand must be fetched from memory |
| imm_value | output | 32 | Immediate operand (immediate mode only) |
| illegal | output | 1 | Mode code was not a legal one |

## Verification
Assertions check on every cycle four things: the one-cycle relation between `in_valid` and `out_valid`, the hold of the outputs on idle cycles, that an illegal or immediate result never requests memory, and that the decoder places each code in exactly one class. The arithmetic can only be shown by the bench's scenarios. These cover each mode's sum, sign extension of negative constants, wraparound past 2^32, and register zero masking a nonzero data input. The bench compares them against sums it forms on its own from random and directed operands.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int unsigned EAG_ADDR_W  = 32;
    localparam int unsigned EAG_CONST_W = 16;
    localparam int unsigned EAG_SEL_W   = 5;
    localparam int unsigned EAG_MODE_W  = 3;

    // Mode codes; the numeric values are decoded by the instruction stage.
    localparam logic [EAG_MODE_W-1:0] MD_ABS   = 3'd0;
    localparam logic [EAG_MODE_W-1:0] MD_IMM   = 3'd1;
    localparam logic [EAG_MODE_W-1:0] MD_IND   = 3'd2;
    localparam logic [EAG_MODE_W-1:0] MD_IDX   = 3'd3;
    localparam logic [EAG_MODE_W-1:0] MD_BIDX  = 3'd4;
    localparam logic [EAG_MODE_W-1:0] MD_BIDXK = 3'd5;

    // Control word produced by the mode decoder.
    typedef struct packed {
        logic add_const;   // constant enters the address sum
        logic add_base;    // base register enters the sum
        logic add_index;   // index register enters the sum
        logic is_imm;      // constant is the operand
        logic is_mem;      // operand lives in memory
        logic is_bad;      // unknown mode code
    } eag_ctl_t;

    function automatic logic mode_is_legal(input logic [EAG_MODE_W-1:0] m);
        return m <= MD_BIDXK;
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [EAG_MODE_W-1:0] mode,
    output eag_ctl_t              ctl
);

    always_comb begin
        ctl = '0;
        if (!mode_is_legal(mode)) begin
            ctl.is_bad = 1'b1;
        end else begin
            unique case (mode)
                MD_ABS:   begin ctl.add_const = 1'b1; ctl.is_mem = 1'b1; end
                MD_IMM:   begin ctl.is_imm = 1'b1; end
                MD_IND:   begin ctl.add_base = 1'b1; ctl.is_mem = 1'b1; end
                MD_IDX:   begin ctl.add_const = 1'b1; ctl.add_base = 1'b1;
                                ctl.is_mem = 1'b1; end
                MD_BIDX:  begin ctl.add_base = 1'b1; ctl.add_index = 1'b1;
                                ctl.is_mem = 1'b1; end
                default:  begin ctl.add_const = 1'b1; ctl.add_base = 1'b1;
                                ctl.add_index = 1'b1; ctl.is_mem = 1'b1; end
            endcase
        end
    end

    // R10: every code lands in exactly one class (memory, immediate, illegal)
    always_comb begin
        a_r10_class_onehot: assert ($onehot({ctl.is_mem, ctl.is_imm, ctl.is_bad}) || $isunknown(mode));
    end

endmodule

// File: rtl/eag_sext.sv
module eag_sext #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 32
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int unsigned EXT_W = OUT_W - IN_W;

    generate
        if (EXT_W == 0) begin : g_same
            assign dout = din;
        end else begin : g_ext
            assign dout = {{EXT_W{din[IN_W-1]}}, din};
        end
    endgenerate
endmodule

// File: rtl/eag_operand_gate.sv
module eag_operand_gate #(
    parameter int unsigned W     = 32,
    parameter int unsigned SEL_W = 5
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     val,
    output logic [W-1:0]     q
);
    // Register number zero is hard-wired to read as zero.
    assign q = (en && (sel != '0)) ? val : '0;
endmodule

// File: rtl/eag_adder3.sv
module eag_adder3 #(
    parameter int unsigned W       = 32,
    parameter bit          USE_CSA = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    generate
        if (USE_CSA) begin : g_csa
            // One carry-save layer, then a single carry-propagate add.
            logic [W-1:0] ps;
            logic [W-1:0] cy;
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign ps[i] = a[i] ^ b[i] ^ c[i];
                if (i == 0) begin : g_lsb
                    assign cy[0] = 1'b0;
                end else begin : g_up
                    assign cy[i] = (a[i-1] & b[i-1]) | (a[i-1] & c[i-1]) | (b[i-1] & c[i-1]);
                end
            end
            assign sum = ps + cy;
        end else begin : g_chain
            logic [W-1:0] ab;
            assign ab  = a + b;
            assign sum = ab + c;
        end
    endgenerate
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
#(
    parameter int unsigned ADDR_W  = EAG_ADDR_W,
    parameter int unsigned CONST_W = EAG_CONST_W,
    parameter int unsigned SEL_W   = EAG_SEL_W,
    parameter bit          USE_CSA = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [EAG_MODE_W-1:0] mode,
    input  logic [CONST_W-1:0]    konst,
    input  logic [SEL_W-1:0]      base_sel,
    input  logic [ADDR_W-1:0]     base_val,
    input  logic [SEL_W-1:0]      index_sel,
    input  logic [ADDR_W-1:0]     index_val,
    output logic                  out_valid,
    output logic [ADDR_W-1:0]     ea,
    output logic                  mem_access,
    output logic [ADDR_W-1:0]     imm_value,
    output logic                  illegal
);

    eag_ctl_t          ctl;
    logic [ADDR_W-1:0] kx;
    logic [ADDR_W-1:0] op_k;
    logic [ADDR_W-1:0] op_b;
    logic [ADDR_W-1:0] op_i;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] ea_d;
    logic [ADDR_W-1:0] imm_d;

    eag_decode u_dec (.mode(mode), .ctl(ctl));

    eag_sext #(.IN_W(CONST_W), .OUT_W(ADDR_W)) u_sext (.din(konst), .dout(kx));

    assign op_k = ctl.add_const ? kx : '0;

    eag_operand_gate #(.W(ADDR_W), .SEL_W(SEL_W)) u_gate_b (
        .en(ctl.add_base), .sel(base_sel), .val(base_val), .q(op_b));

    eag_operand_gate #(.W(ADDR_W), .SEL_W(SEL_W)) u_gate_i (
        .en(ctl.add_index), .sel(index_sel), .val(index_val), .q(op_i));

    eag_adder3 #(.W(ADDR_W), .USE_CSA(USE_CSA)) u_add (
        .a(op_k), .b(op_b), .c(op_i), .sum(sum));

    assign ea_d  = ctl.is_mem ? sum : '0;
    assign imm_d = ctl.is_imm ? kx  : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            ea         <= '0;
            mem_access <= 1'b0;
            imm_value  <= '0;
            illegal    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ea         <= ea_d;
                mem_access <= ctl.is_mem;
                imm_value  <= imm_d;
                illegal    <= ctl.is_bad;
            end
        end
    end

    // R2: result valid exactly one cycle after a request
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R12: idle cycles leave the result untouched
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(ea) && $stable(imm_value) && $stable(mem_access) && $stable(illegal)));

    // R10: an illegal code never requests memory nor yields an operand
    a_r10_bad_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_access && ea == '0 && imm_value == '0));

    // R10: codes above the legal range are flagged on the next cycle
    a_r10_flag_bad: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_is_legal(mode)) |=> illegal);

    // R4: a memory operand never comes with an immediate value
    a_r4_imm_exclusive: assert property (@(posedge clk) disable iff (rst)
        mem_access |-> (imm_value == '0));

endmodule

// File: tb/tb_eag_top.sv
module tb_eag_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  mode;
    logic [15:0] konst;
    logic [4:0]  base_sel;
    logic [31:0] base_val;
    logic [4:0]  index_sel;
    logic [31:0] index_val;
    logic        out_valid;
    logic [31:0] ea;
    logic        mem_access;
    logic [31:0] imm_value;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eag_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .konst(konst),
        .base_sel(base_sel), .base_val(base_val), .index_sel(index_sel),
        .index_val(index_val), .out_valid(out_valid), .ea(ea),
        .mem_access(mem_access), .imm_value(imm_value), .illegal(illegal));

    function automatic logic [31:0] sx(input logic [15:0] k);
        return {{16{k[15]}}, k};
    endfunction

    function automatic logic [31:0] rd(input logic [4:0] s, input logic [31:0] v);
        return (s == 5'd0) ? 32'd0 : v;
    endfunction

    function automatic logic [31:0] exp_ea(input logic [2:0] m, input logic [15:0] k,
                                           input logic [4:0] bs, input logic [31:0] bv,
                                           input logic [4:0] is, input logic [31:0] iv);
        case (m)
            3'd0:    return sx(k);
            3'd2:    return rd(bs, bv);
            3'd3:    return sx(k) + rd(bs, bv);
            3'd4:    return rd(bs, bv) + rd(is, iv);
            3'd5:    return sx(k) + rd(bs, bv) + rd(is, iv);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one request and check the registered result one edge later.
    task automatic run(input logic [2:0] m, input logic [15:0] k,
                       input logic [4:0] bs, input logic [31:0] bv,
                       input logic [4:0] is, input logic [31:0] iv, input string tag);
        @(negedge clk);
        in_valid = 1'b1; mode = m; konst = k;
        base_sel = bs; base_val = bv; index_sel = is; index_val = iv;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " ea"}, ea, exp_ea(m, k, bs, bv, is, iv));
        chk({tag, " mem"}, {31'd0, mem_access}, {31'd0, (m <= 3'd5 && m != 3'd1)});
        chk({tag, " imm"}, imm_value, (m == 3'd1) ? sx(k) : 32'd0);
        chk({tag, " R10 flag"}, {31'd0, illegal}, {31'd0, (m > 3'd5)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] h_ea;
        logic [31:0] h_imm;
        rst = 1'b1; in_valid = 1'b0; mode = '0; konst = '0;
        base_sel = '0; base_val = '0; index_sel = '0; index_val = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 ea", ea, 32'd0);
        chk("R1 mem", {31'd0, mem_access}, 32'd0);
        chk("R1 imm", imm_value, 32'd0);
        chk("R1 illegal", {31'd0, illegal}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {31'd0, out_valid}, 32'd0);

        // Directed corners
        run(3'd0, 16'h8004, 5'd3, 32'h1111_1111, 5'd4, 32'h2, "R3 negative abs");
        run(3'd1, 16'hFFFE, 5'd3, 32'h1111_1111, 5'd4, 32'h2, "R4 immediate");
        run(3'd2, 16'h0010, 5'd7, 32'hDEAD_BEE0, 5'd0, 32'h0, "R5 indirect");
        run(3'd3, 16'h8000, 5'd2, 32'h0001_0000, 5'd0, 32'h0, "R6 neg index");
        run(3'd3, 16'h0040, 5'd0, 32'hFFFF_0000, 5'd0, 32'h0, "R9 X(R0) absolute");
        run(3'd4, 16'h0000, 5'd1, 32'h0000_1000, 5'd9, 32'h0000_0024, "R7 base-index");
        run(3'd4, 16'h0000, 5'd1, 32'h0000_1000, 5'd0, 32'h5555_5555, "R9 index R0");
        run(3'd5, 16'h0001, 5'd6, 32'hFFFF_FFFF, 5'd8, 32'h0000_0001, "R11 wrap");
        run(3'd5, 16'hFFFC, 5'd6, 32'h0000_0100, 5'd8, 32'h0000_0020, "R8 three-term");
        run(3'd6, 16'h1234, 5'd6, 32'h0000_0100, 5'd8, 32'h0000_0020, "R10 code6");
        run(3'd7, 16'h1234, 5'd6, 32'h0000_0100, 5'd8, 32'h0000_0020, "R10 code7");
        run(3'd5, 16'h7FFF, 5'd31, 32'h8000_0000, 5'd31, 32'h8000_0000, "R11 same reg wrap");

        // R12: idle cycle with changed inputs leaves outputs alone
        h_ea = ea; h_imm = imm_value;
        @(negedge clk);
        mode = 3'd2; base_sel = 5'd4; base_val = 32'hCAFE_0000; konst = 16'h0F0F;
        @(negedge clk);
        chk("R12 valid low", {31'd0, out_valid}, 32'd0);
        chk("R12 ea held", ea, h_ea);
        chk("R12 imm held", imm_value, h_imm);
        chk("R12 mem held", {31'd0, mem_access}, 32'd1);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  m;
            logic [4:0]  bs;
            logic [4:0]  is;
            m  = 3'($urandom_range(0, 7));
            bs = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            is = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            run(m, 16'($urandom), bs, $urandom, is, $urandom, req_of(m));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule